// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache Controller

The block sits between a processor read port and a slower main-memory port and keeps recently used blocks of four words close to the processor. Each word address is split into a block offset, a set index and a tag. The stored tags of both ways in the indexed set are compared in parallel with the address tag, qualified by their valid bits. When one of them matches, the addressed word comes straight from the local data store. Otherwise the whole block is fetched from memory as four word beats and installed in a chosen way, and the requested word is then returned. The processor waits for a response before it may issue another request.

Victim selection fills an empty way before it evicts a valid way. When both ways are valid, a per-set least-recently-used bit names the victim. That bit is updated on every hit and on every completed refill. Control is one finite-state machine with five states. IDLE accepts a request (IDLE→LOOKUP). LOOKUP compares the tags and moves to REPLY on a hit (LOOKUP→REPLY) or to FETCH on a miss (LOOKUP→FETCH). FETCH issues the block request and invalidates the victim line (FETCH→FILL). FILL writes each arriving beat and stays put until the fourth beat arrives (FILL→FILL, then FILL→REPLY). REPLY presents the word for one cycle (REPLY→IDLE).

Top module: `cache2w_top`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses. req_ready is high, and resp_valid and mem_req are low.
- R2: The word address is split with bits [1:0] as the word offset within the block, the next log2(SETS) bits as the set index, and the remaining upper bits as the tag.
- R3: On a hit, resp_valid is high for exactly one cycle with the addressed word. It appears in the second cycle after the cycle in which the request was accepted, and no memory request is made.
- R4: On a miss, mem_req is high for exactly one cycle, in the cycle after the lookup. mem_addr then carries the block-aligned word address (offset bits zero).
- R5: A refill takes four beats, qualified by mem_rvalid, in ascending offset order. The beats may be spread out by any memory latency or gap. resp_valid carries the requested word in the cycle after the fourth beat.
- R6: req_ready is high only while the controller is idle. A request presented at any other time is ignored and installs nothing.
- R7: On a miss, an invalid way of the set is filled before any valid way is evicted.
- R8: With both ways valid, the victim is the least recently used way of the set. Both hits and completed refills count as uses.
- R9: A refilled line becomes valid only after its last beat has been written, so the refilled block hits on the next access to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor read request |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Controller idle and accepting a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | DATA_W | Requested word |
| mem_req | output | 1 | One-cycle block read request to memory |
| mem_addr | output | ADDR_W | Block-aligned word address of the refill |
| mem_rvalid | input | 1 | Refill beat valid |
| mem_rdata | input | DATA_W | Refill beat data |

## Verification
The bench drives a set through the order empty way, second empty way, then evictions. A design that ignored valid bits when choosing a victim would throw out a live block while a way stood empty, and the next access to that block would miss. Hits placed between misses pull recency away from the last fill, so a design that updated recency only on refills would evict the block that was just read. Refills run with no latency, long latency and gaps between beats. A beat counter that assumed back-to-back data would then show up as a wrong word or a wrong response cycle. A request held high through a whole miss must install nothing, so a controller that sampled its address port while busy would turn a later access to the held address into a hit.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
    localparam int NWAYS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FETCH,
        ST_FILL,
        ST_REPLY
    } cstate_t;
endpackage

// File: rtl/c2w_tags.sv
module c2w_tags
    import cache2w_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 7,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic             hit_way,
    output logic             victim_way,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic             inval_en,
    input  logic             fill_en,
    input  logic             fill_way,
    input  logic [TAG_W-1:0] fill_tag
);
    logic [NWAYS-1:0] valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][NWAYS];
    logic             lru_q   [SETS];   // way to evict next
    logic [NWAYS-1:0] way_hit;

    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign way_hit[w] = valid_q[set_idx][w] && (tag_q[set_idx][w] == look_tag);
    end

    assign hit     = |way_hit;
    assign hit_way = way_hit[1];

    always_comb begin
        if (!valid_q[set_idx][0])      victim_way = 1'b0;
        else if (!valid_q[set_idx][1]) victim_way = 1'b1;
        else                           victim_way = lru_q[set_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                lru_q[s]   <= 1'b0;
            end
        end else begin
            if (inval_en) valid_q[set_idx][fill_way] <= 1'b0;
            if (fill_en)  valid_q[set_idx][fill_way] <= 1'b1;
            if (touch_en) lru_q[set_idx] <= ~touch_way;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[set_idx][fill_way] <= fill_tag;
    end

    // R3: a tag may live in at most one way of a set
    a_r3_single_way_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    // R7: an invalid way is never passed over for a valid one
    a_r7_empty_way_first: assert property (@(posedge clk) disable iff (!rst_n)
        inval_en |-> !valid_q[set_idx][fill_way] || (&valid_q[set_idx]));
endmodule

// File: rtl/c2w_data.sv
module c2w_data
    import cache2w_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS),
    localparam int OFF_W = $clog2(WORDS),
    localparam int DEPTH = NWAYS * SETS * WORDS,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic              rd_way,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] store_q [DEPTH];
    logic [AW-1:0]     rd_ix;
    logic [AW-1:0]     wr_ix;

    assign rd_ix   = {rd_way, set_idx, rd_off};
    assign wr_ix   = {wr_way, set_idx, wr_off};
    assign rd_data = store_q[rd_ix];

    always_ff @(posedge clk) begin
        if (wr_en) store_q[wr_ix] <= wr_data;
    end
endmodule

// File: rtl/c2w_ctrl.sv
module c2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SETS   = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS),
    localparam int OFF_W = $clog2(WORDS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  cur_tag,
    output logic [OFF_W-1:0]  cur_off,
    input  logic              hit,
    input  logic              hit_way,
    input  logic              victim_way,
    output logic              touch_en,
    output logic              touch_way,
    output logic              inval_en,
    output logic              fill_en,
    output logic              fill_way,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [OFF_W-1:0]  wr_off
);
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

    cstate_t           state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              way_q;
    logic [OFF_W-1:0]  beat_q;
    logic [DATA_W-1:0] word_q;
    logic              last_beat;

    assign cur_off   = addr_q[OFF_W-1:0];
    assign set_idx   = addr_q[OFF_W +: IDX_W];
    assign cur_tag   = addr_q[ADDR_W-1 -: TAG_W];
    assign last_beat = (state_q == ST_FILL) && mem_rvalid && (beat_q == LAST_BEAT);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = hit ? ST_REPLY : ST_FETCH;
            ST_FETCH:  state_d = ST_FILL;
            ST_FILL:   if (last_beat) state_d = ST_REPLY;
            ST_REPLY:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        mem_req    = 1'b0;
        touch_en   = 1'b0;
        touch_way  = way_q;
        inval_en   = 1'b0;
        fill_en    = 1'b0;
        fill_way   = way_q;
        wr_en      = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_LOOKUP: begin
                touch_en  = hit;
                touch_way = hit_way;
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                inval_en = 1'b1;
            end
            ST_FILL: begin
                wr_en    = mem_rvalid;
                fill_en  = last_beat;
                touch_en = last_beat;
            end
            ST_REPLY:  resp_valid = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end

    assign wr_off    = beat_q;
    assign mem_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign resp_data = word_q;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            way_q  <= 1'b0;
            beat_q <= '0;
            word_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) addr_q <= req_addr;
            if (state_q == ST_LOOKUP) begin
                way_q  <= victim_way;
                beat_q <= '0;
                if (hit) word_q <= rd_data;
            end
            if (state_q == ST_FILL && mem_rvalid) begin
                beat_q <= beat_q + 1'b1;
                if (beat_q == cur_off) word_q <= mem_rdata;
            end
        end
    end

    a_r3_reply_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r4_fetch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || resp_valid) |-> !req_ready);

    a_r5_reply_after_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> resp_valid);

    a_r6_ready_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> req_ready);
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SETS   = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS),
    localparam int OFF_W = $clog2(WORDS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [IDX_W-1:0]  set_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic [OFF_W-1:0]  cur_off;
    logic              hit, hit_way, victim_way;
    logic              touch_en, touch_way, inval_en, fill_en, fill_way;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [OFF_W-1:0]  wr_off;

    c2w_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .set_idx(set_idx), .cur_tag(cur_tag), .cur_off(cur_off),
        .hit(hit), .hit_way(hit_way), .victim_way(victim_way),
        .touch_en(touch_en), .touch_way(touch_way), .inval_en(inval_en),
        .fill_en(fill_en), .fill_way(fill_way),
        .rd_data(rd_data), .wr_en(wr_en), .wr_off(wr_off)
    );

    c2w_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .look_tag(cur_tag),
        .hit(hit), .hit_way(hit_way), .victim_way(victim_way),
        .touch_en(touch_en), .touch_way(touch_way), .inval_en(inval_en),
        .fill_en(fill_en), .fill_way(fill_way), .fill_tag(cur_tag)
    );

    c2w_data #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk(clk), .set_idx(set_idx),
        .rd_way(hit_way), .rd_off(cur_off), .rd_data(rd_data),
        .wr_en(wr_en), .wr_way(fill_way), .wr_off(wr_off), .wr_data(mem_rdata)
    );
endmodule

// File: tb/sim_cache2w_top.sv
module sim_cache2w_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int SETS   = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready, resp_valid, mem_req;
    logic [DATA_W-1:0] resp_data;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    cache2w_top #(.ADDR_W(ADDR_W), .SETS(SETS), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int lat = 0, gap = 0;
    int mreq_cnt = 0;
    int last_maddr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] mword(input int a);
        return DATA_W'(a * 32'h9E37_79B1) ^ 32'hC0DE_0000 ^ DATA_W'(a);
    endfunction

    // memory model: latency before the first beat, gap between beats
    int pend = 0, cnt = 0, beat = 0, base = 0;
    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            pend = 1; cnt = lat; beat = 0; base = int'(mem_addr);
        end else if (pend != 0) begin
            if (cnt > 0) cnt--;
            else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mword(base + beat);
                beat++;
                if (beat == 4) pend = 0;
                else cnt = gap;
            end
        end
    end

    always @(posedge clk) if (mem_req) begin
        mreq_cnt++;
        last_maddr = int'(mem_addr);
    end

    // behavioural reference: valid, tag, least recently used way per set
    int rv [SETS][2];
    int rt [SETS][2];
    int rl [SETS];

    task automatic access(input int a, input bit jam, input int jam_a, input string req);
        int idx, tg, w, vic, m0, edges, exp_lat;
        bit exp_hit, busy_ok;
        idx = (a >> 2) % SETS;
        tg  = a >> 5;
        exp_hit = 0; w = 0;
        for (int k = 0; k < 2; k++)
            if (rv[idx][k] != 0 && rt[idx][k] == tg) begin exp_hit = 1; w = k; end
        exp_lat = exp_hit ? 2 : 4 + lat + 3 * (gap + 1);

        @(negedge clk);
        chk(req_ready == 1'b1 && resp_valid == 1'b0, "R6 ready when idle", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(a);
        m0 = mreq_cnt;
        @(posedge clk);
        @(negedge clk);
        if (jam) req_addr = ADDR_W'(jam_a);
        else     req_valid = 1'b0;
        edges = 1;
        busy_ok = 1;
        while (!resp_valid && edges < 200) begin
            if (req_ready) busy_ok = 0;
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(busy_ok, "R6 not ready while busy", 0, 0);
        chk(edges == exp_lat, exp_hit ? {req, " R3 hit latency"} : {req, " R5 miss latency"},
            edges, exp_lat);
        chk(resp_data == mword(a), {req, " R2 word"}, int'(resp_data), int'(mword(a)));
        chk(mreq_cnt - m0 == (exp_hit ? 0 : 1), {req, " R4 memory requests"},
            mreq_cnt - m0, exp_hit ? 0 : 1);
        if (!exp_hit)
            chk(last_maddr == (a & ~3), {req, " R4 block address"}, last_maddr, a & ~3);

        if (exp_hit) rl[idx] = 1 - w;
        else begin
            if (rv[idx][0] == 0)      vic = 0;
            else if (rv[idx][1] == 0) vic = 1;
            else                      vic = rl[idx];
            rv[idx][vic] = 1; rt[idx][vic] = tg; rl[idx] = 1 - vic;
        end
    endtask

    function automatic int mk(input int tg, input int idx, input int off);
        return (tg << 5) | (idx << 2) | off;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog R5 actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int x;
        for (int s = 0; s < SETS; s++) begin
            rl[s] = 0;
            for (int k = 0; k < 2; k++) begin rv[s][k] = 0; rt[s][k] = 0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
        chk(resp_valid == 1'b0, "R1 resp_valid", int'(resp_valid), 0);
        chk(mem_req == 1'b0, "R1 mem_req", int'(mem_req), 0);

        // R1/R4/R5: cold miss, then hits on every word of the block (R3)
        access(mk(1, 2, 1), 0, 0, "R1 cold");
        for (int o = 0; o < 4; o++) access(mk(1, 2, o), 0, 0, "R3 hit");
        // R7: second tag goes to the empty way, both stay resident
        lat = 3;
        access(mk(2, 2, 3), 0, 0, "R7 fill empty");
        access(mk(1, 2, 0), 0, 0, "R7 first kept");
        access(mk(2, 2, 2), 0, 0, "R7 second kept");
        // R8: tag 1 touched last by hit -> tag 2 is evicted by tag 3
        access(mk(1, 2, 2), 0, 0, "R8 touch");
        gap = 2;
        access(mk(3, 2, 0), 0, 0, "R8 evict");
        access(mk(1, 2, 3), 0, 0, "R8 survivor");
        access(mk(2, 2, 1), 0, 0, "R8 evicted");
        // R9: refilled block hits right away
        access(mk(2, 2, 0), 0, 0, "R9 valid after fill");
        // R6: request held high with another address through a miss
        lat = 5; gap = 1;
        access(mk(4, 5, 2), 1, mk(6, 5, 1), "R6 held");
        access(mk(6, 5, 1), 0, 0, "R6 not installed");
        // R5: refills with assorted latency and gaps, mixed with hits
        x = 32'h1ACE;
        for (int i = 0; i < 300; i++) begin
            x = (x * 1103515245 + 12345) & 32'h7FFF_FFFF;
            lat = i % 5;
            gap = (i / 7) % 3;
            access(mk((x >> 8) % 3, (x >> 4) % SETS, x % 4), 0, 0, "R8 mix");
        end
        @(negedge clk);
        chk(resp_valid == 1'b0 && req_ready == 1'b1, "R3 single reply", int'(resp_valid), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule